// File: doc/BRIEF.md
# Colour Palette Register Front End

This block is the bus-facing side of a 256-entry colour lookup palette. Each entry holds separate 8-bit red, green and blue values. Software picks an entry by writing its number to the index register. It then writes three words to the data register, which fill red, green and blue in that order. After the blue write the index steps to the next entry, so a run of colours can be loaded without rewriting the index. Only the top byte of every 32-bit word carries information.

Reads on the bus always return zero. The pixel path reads the palette through a separate combinational port. Each component write also raises a one-cycle strobe that carries the entry number, so a downstream converted-colour table can refresh that entry.

Top module: `pal_dac`

## Requirements
- R1: A 4-byte write at offset 0x0 loads the index from wdata[31:24] and sets the colour phase back to red.
- R2: 4-byte writes at offset 0x4 store wdata[31:24] into the red, green and blue component of the current entry in turn, one component per write. wdata[23:0] is ignored.
- R3: The blue write increments the index modulo 256 and returns the phase to red, so the next data write targets red of the following entry. Entry 255 is followed by entry 0.
- R4: Writes to offset 0x8, to offset 0xC, or to any offset that is not a multiple of 4 change no palette entry, no index and no phase.
- R5: A write with wr_word low (an access that is not 4 bytes) has no effect, and rdata is always zero.
- R6: After reset every entry is (0,0,0) except entry 255, which is (255,255,255). The index is 0, the phase is red, and upd_valid is low.
- R7: upd_valid is high in the cycle after each component write, with upd_idx equal to the entry that was written. It is low in every other cycle.
- R8: An index write in the middle of a sequence keeps the components already written to the old entry, and the next data write goes to red of the new entry.
- R9: pix_red, pix_grn and pix_blu show the stored components of entry pix_idx without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_word | input | 1 | High when the access is 4 bytes wide |
| addr | input | 4 | Byte offset inside the 16-byte register window |
| wdata | input | 32 | Write data; only bits 31:24 are used |
| rdata | output | 32 | Bus read data, always zero |
| pix_idx | input | 8 | Entry number requested by the pixel path |
| pix_red | output | 8 | Red component of entry pix_idx |
| pix_grn | output | 8 | Green component of entry pix_idx |
| pix_blu | output | 8 | Blue component of entry pix_idx |
| upd_valid | output | 1 | One-cycle pulse after a component write |
| upd_idx | output | 8 | Entry number that the pulse refers to |

## Verification
The first pattern writes one complete triple followed by a fourth data word. It shows whether the components land in red, green, blue order and whether the index advances only after blue. Loading index 255 and continuing past it tests the modulo wrap into entry 0. Writes to the other offsets, to misaligned offsets and with narrow access size are each followed by a real data write. That write lands in red of the unchanged entry only if the ignored access disturbed neither the index nor the phase. A sequence broken by an index write tells a design that resets the phase apart from one that carries it over or clears the partly written entry.

// File: rtl/pal_dac.sv
module pal_dac #(
  parameter int IDX_W  = 8,
  parameter int CH_W   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [CH_W-1:0]   pix_red,
  output logic [CH_W-1:0]   pix_grn,
  output logic [CH_W-1:0]   pix_blu,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_idx
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] OFS_IDX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DAT = ADDR_W'(4);

  typedef enum logic [1:0] {PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2} phase_t;

  logic [CH_W-1:0]  red_q [ENTRIES];
  logic [CH_W-1:0]  grn_q [ENTRIES];
  logic [CH_W-1:0]  blu_q [ENTRIES];
  logic [IDX_W-1:0] idx_q;
  phase_t           phase_q;

  wire [CH_W-1:0]  comp   = wdata[DATA_W-1 -: CH_W];
  wire [IDX_W-1:0] idx_in = wdata[DATA_W-1 -: IDX_W];
  wire             unused_low = ^wdata[DATA_W-CH_W-1:0];
  wire             wr_ok  = wr_en & wr_word;
  wire             wr_idx = wr_ok & (addr == OFS_IDX);
  wire             wr_dat = wr_ok & (addr == OFS_DAT);

  assign rdata   = '0;
  assign pix_red = red_q[pix_idx];
  assign pix_grn = grn_q[pix_idx];
  assign pix_blu = blu_q[pix_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        red_q[i] <= (i == ENTRIES - 1) ? '1 : '0;
        grn_q[i] <= (i == ENTRIES - 1) ? '1 : '0;
        blu_q[i] <= (i == ENTRIES - 1) ? '1 : '0;
      end
    end else if (wr_dat) begin
      case (phase_q)
        PH_R:    red_q[idx_q] <= comp;
        PH_G:    grn_q[idx_q] <= comp;
        PH_B:    blu_q[idx_q] <= comp;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      phase_q   <= PH_R;
      upd_valid <= 1'b0;
      upd_idx   <= '0;
    end else begin
      upd_valid <= wr_dat && (phase_q != 2'd3);
      if (wr_dat) upd_idx <= idx_q;
      if (wr_idx) begin
        idx_q   <= idx_in;
        phase_q <= PH_R;
      end else if (wr_dat) begin
        case (phase_q)
          PH_R:    phase_q <= PH_G;
          PH_G:    phase_q <= PH_B;
          PH_B: begin
            phase_q <= PH_R;
            idx_q   <= idx_q + 1'b1;
          end
          default: phase_q <= PH_R;
        endcase
      end
    end
  end
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_word,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        phase_q,
  input logic              upd_valid,
  input logic [IDX_W-1:0]  upd_idx
);
  wire unused_low = ^wdata[DATA_W-IDX_W-1:0];
  wire ok    = wr_en & wr_word;
  wire w_idx = ok & (addr == ADDR_W'(0));
  wire w_dat = ok & (addr == ADDR_W'(4));

  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    w_idx |=> (idx_q == $past(wdata[DATA_W-1 -: IDX_W])) && (phase_q == 2'd0));

  a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  a_r3_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (w_dat && phase_q == 2'd2) |=> (idx_q == $past(idx_q) + IDX_W'(1)) && (phase_q == 2'd0));

  a_r4_ignored_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_idx && !w_dat) |=> $stable(idx_q) && $stable(phase_q) && !upd_valid);

  a_r5_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word) |=> !upd_valid);

  a_r7_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    w_dat |=> upd_valid && (upd_idx == $past(idx_q)));

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !w_dat |=> !upd_valid);
endmodule

bind pal_dac pal_dac_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .addr(addr),
  .wdata(wdata), .idx_q(idx_q), .phase_q(phase_q), .upd_valid(upd_valid),
  .upd_idx(upd_idx)
);

// File: tb/pal_dac_test.sv
module pal_dac_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pix_idx = '0;
  logic [7:0]  pix_red, pix_grn, pix_blu;
  logic        upd_valid;
  logic [7:0]  upd_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_dac uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pix_idx(pix_idx), .pix_red(pix_red),
    .pix_grn(pix_grn), .pix_blu(pix_blu), .upd_valid(upd_valid), .upd_idx(upd_idx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic word = 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_word = word; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wr_word = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic chk_entry(string req, logic [7:0] i, logic [23:0] rgb);
    pix_idx = i;
    #1;
    chk(req, {8'h00, pix_red, pix_grn, pix_blu}, {8'h00, rgb});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_entry("R6 entry0", 8'h00, 24'h000000);
    chk_entry("R6 entry128", 8'h80, 24'h000000);
    chk_entry("R6 entry254", 8'hFE, 24'h000000);
    chk_entry("R6 entry255", 8'hFF, 24'hFFFFFF);
    chk("R6 upd_valid", {31'b0, upd_valid}, 32'd0);
    chk("R5 rdata", rdata, 32'd0);
  endtask

  task automatic t_full_entry;
    wr(4'h0, 32'h10_000000);
    wr(4'h4, 32'h11_ABCDEF);
    chk("R7 strobe red", {23'b0, upd_valid, upd_idx}, {23'b0, 1'b1, 8'h10});
    wr(4'h4, 32'h22_123456);
    chk("R7 strobe green", {23'b0, upd_valid, upd_idx}, {23'b0, 1'b1, 8'h10});
    wr(4'h4, 32'h33_FFFFFF);
    chk("R7 strobe blue", {23'b0, upd_valid, upd_idx}, {23'b0, 1'b1, 8'h10});
    chk_entry("R2 rgb order", 8'h10, 24'h112233);
    @(negedge clk);
    chk("R7 strobe single cycle", {31'b0, upd_valid}, 32'd0);
    wr(4'h4, 32'h44_000000);
    chk("R3 auto increment strobe", {24'b0, upd_idx}, 32'h11);
    chk_entry("R3 next entry red", 8'h11, 24'h440000);
    chk_entry("R2 old entry kept", 8'h10, 24'h112233);
    chk("R5 rdata after writes", rdata, 32'd0);
  endtask

  task automatic t_wrap;
    wr(4'h0, 32'hFF_000000);
    wr(4'h4, 32'h01_000000);
    wr(4'h4, 32'h02_000000);
    wr(4'h4, 32'h03_000000);
    chk_entry("R2 entry255 written", 8'hFF, 24'h010203);
    wr(4'h4, 32'h55_000000);
    chk("R3 wrap strobe idx", {24'b0, upd_idx}, 32'h00);
    chk_entry("R3 wrap to entry0", 8'h00, 24'h550000);
  endtask

  task automatic t_ignore;
    wr(4'h0, 32'h20_000000);
    wr(4'h8, 32'h30_000000);
    chk("R4 offset8 no strobe", {31'b0, upd_valid}, 32'd0);
    wr(4'hC, 32'h31_000000);
    chk("R4 offsetC no strobe", {31'b0, upd_valid}, 32'd0);
    wr(4'h1, 32'h32_000000);
    wr(4'h5, 32'h33_000000);
    chk("R4 misaligned no strobe", {31'b0, upd_valid}, 32'd0);
    wr(4'h0, 32'h34_000000, 1'b0);
    wr(4'h4, 32'h35_000000, 1'b0);
    chk("R5 narrow no strobe", {31'b0, upd_valid}, 32'd0);
    chk_entry("R4 entry20 untouched", 8'h20, 24'h000000);
    chk_entry("R5 entry34 untouched", 8'h34, 24'h000000);
    wr(4'h4, 32'h77_000000);
    chk("R4 index unchanged", {24'b0, upd_idx}, 32'h20);
    chk_entry("R4 phase unchanged", 8'h20, 24'h770000);
  endtask

  task automatic t_mid;
    wr(4'h0, 32'h40_000000);
    wr(4'h4, 32'h9A_000000);
    wr(4'h4, 32'h9B_000000);
    wr(4'h0, 32'h41_000000);
    wr(4'h4, 32'h9C_000000);
    chk_entry("R8 old entry partial kept", 8'h40, 24'h9A9B00);
    chk_entry("R8 new entry red", 8'h41, 24'h9C0000);
    wr(4'h4, 32'h9D_000000);
    chk_entry("R8 new entry green", 8'h41, 24'h9C9D00);
  endtask

  task automatic t_pixel_port;
    wr(4'h0, 32'h60_000000);
    wr(4'h4, 32'hA1_000000);
    wr(4'h4, 32'hA2_000000);
    wr(4'h4, 32'hA3_000000);
    chk_entry("R9 lookup 60", 8'h60, 24'hA1A2A3);
    chk_entry("R9 lookup 10", 8'h10, 24'h112233);
    chk_entry("R9 lookup 5F", 8'h5F, 24'h000000);
  endtask

  initial begin
    t_reset;
    t_full_entry;
    t_wrap;
    t_ignore;
    t_mid;
    t_pixel_port;
    t_reset;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule